// File: doc/BRIEF.md
# Serial Field Memory Write Port

This block is the write side of a dual-port serial field memory. It runs in the write clock domain, keeps the write address pointer, and issues address, data and a write strobe to a plain synchronous RAM that sits outside it. Each rising edge of the write clock is exactly one of four things: a pointer reset, a hold, an advance that stores a word, or an advance that stores nothing.

The block has two gating inputs. The write enable freezes the pointer when low. The input enable only masks the store: the pointer keeps advancing, so a caller can overwrite a rectangle inside a stored field and leave the surrounding words untouched.

Write requests leave the block one clock after they are sampled. This registered stage gives the write path a one-cycle lag against the read side, so parts can be chained without glue. The depth is a parameter; the full-size default is 262,144 words of 12 bits.

Top module: `field_wr_port`

## Requirements
- R1: An accepted reset strobe (`wr_rst` high at a rising edge) sets `wptr` to 0 at that edge. The levels of `wr_en` and `in_en` are ignored in that cycle, and `mem_we` is 0 after it.
- R2: With `wr_en` low and no accepted reset, `wptr` keeps its value and `mem_we` is 0 after the edge.
- R3: With `wr_en` and `in_en` both high and no accepted reset, `din` is written at the current `wptr`, and `wptr` then advances by one.
- R4: With `wr_en` high and `in_en` low, no store is issued (`mem_we` 0), but `wptr` still advances by one. The RAM word at that address keeps its old content.
- R5: A store sampled at edge k shows on `mem_we`/`mem_addr`/`mem_data` after edge k, and lands in the RAM at edge k+1.
- R6: When `wptr` equals DEPTH-1 and it advances, it wraps to 0.
- R7: A reset strobe is accepted only if `wr_rst` was sampled low at the two preceding edges. Otherwise the strobe is ignored, the cycle acts as a normal write cycle, and the sticky flag `rst_err` goes to 1 and stays there until `rst_n`.
- R8: After `rst_n` is released, `wptr`=0, `mem_we`=0 and `rst_err`=0, and the first strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_rst | input | 1 | Write pointer reset strobe |
| wr_en | input | 1 | Write enable; low freezes the pointer |
| in_en | input | 1 | Input enable; low masks the store only |
| din | input | DW | Data word to store |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM write address |
| mem_data | output | DW | RAM write data |
| wptr | output | AW | Current write address pointer |
| rst_err | output | 1 | Sticky flag for a reset strobe that came too early |

## Verification
The bench first fills a small RAM with one pattern, then overwrites it after a reset with a partly masked second pattern. A design that stalled the pointer under a low input enable would shift the later words, and one that still stored would destroy the masked words. The pointer is pushed past the last address to catch a missing wrap. Resets are issued with both enables high and both low, which catches a design that lets those levels leak into the reset cycle. A strobe repeated on the next cycle must be rejected, raise the sticky flag, and still act as a normal write. A design that accepted it would read back pointer 0 instead of 1.

// File: rtl/field_wr_port.sv
module field_wr_port #(
  parameter int DW    = 12,
  parameter int DEPTH = 262144,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic          in_en,
  input  logic [DW-1:0] din,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic [AW-1:0] wptr,
  output logic          rst_err
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [1:0]    low_cnt;
  logic          guard_ok;
  logic          rst_take;
  logic          advance;
  logic [AW-1:0] ptr_next;

  assign guard_ok = (low_cnt == 2'd2);
  assign rst_take = wr_rst && guard_ok;
  assign advance  = !rst_take && wr_en;
  assign ptr_next = (wptr == LAST) ? '0 : wptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= 2'd2;
      rst_err <= 1'b0;
    end else begin
      if (wr_rst) low_cnt <= 2'd0;
      else if (!guard_ok) low_cnt <= low_cnt + 2'd1;
      if (wr_rst && !guard_ok) rst_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_we <= advance && in_en;
      if (advance) begin
        mem_addr <= wptr;
        mem_data <= din;
      end
      if (rst_take) wptr <= '0;
      else if (advance) wptr <= ptr_next;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_take |=> (wptr == '0) && !mem_we);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !wr_rst) |=> $stable(wptr) && !mem_we);

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_en && !wr_rst) |=> mem_we && (mem_addr == $past(wptr)) && (mem_data == $past(din)));

  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_en && !wr_rst) |=> !mem_we);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_rst && wptr == LAST) |=> (wptr == '0));

  p_early_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && $past(wr_rst)) |=> rst_err);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_err |=> rst_err);

endmodule

// File: tb/field_wr_port_bench.sv
module field_wr_port_bench;
  localparam int DW = 12;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_rst = 1'b0, wr_en = 1'b0, in_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic mem_we, rst_err;
  logic [AW-1:0] mem_addr, wptr;
  logic [DW-1:0] mem_data;
  logic [DW-1:0] ram [DEPTH];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  field_wr_port #(.DW(DW), .DEPTH(DEPTH)) u_field_wr_port (
    .clk(clk), .rst_n(rst_n), .wr_rst(wr_rst), .wr_en(wr_en), .in_en(in_en),
    .din(din), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .wptr(wptr), .rst_err(rst_err));

  always_ff @(posedge clk) if (mem_we) ram[mem_addr] <= mem_data;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit we, bit ie, logic [DW-1:0] d);
    wr_rst = r; wr_en = we; in_en = ie; din = d;
    @(posedge clk); #1;
  endtask

  task automatic t_reset_state;
    check("R8 wptr", wptr, 0);
    check("R8 mem_we", mem_we, 0);
    check("R8 rst_err", rst_err, 0);
  endtask

  task automatic t_first_fill;
    cyc(1, 1, 1, 12'hFFF);
    check("R1 wptr after reset with enables high", wptr, 0);
    check("R1 no store in reset cycle", mem_we, 0);
    check("R8 first strobe no error", rst_err, 0);
    for (int i = 0; i < DEPTH; i++) begin
      cyc(0, 1, 1, 12'h100 + 12'(i));
      check("R5 mem_we", mem_we, 1);
      check("R5 mem_addr", mem_addr, i);
      check("R5 mem_data", mem_data, 12'h100 + i);
      if (i == DEPTH - 1) check("R6 wrap to zero", wptr, 0);
      else if (i == 0) check("R3 advance", wptr, 1);
    end
    cyc(0, 0, 0, 0);
    check("R3 ram word 0", ram[0], 12'h100);
    check("R3 ram last word", ram[DEPTH-1], 12'h100 + DEPTH - 1);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1, 12'hABC);
      check("R2 pointer held", wptr, 0);
      check("R2 no store", mem_we, 0);
    end
  endtask

  task automatic t_masked_overwrite;
    cyc(1, 0, 0, 0);
    check("R1 wptr after reset with enables low", wptr, 0);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 12'h200 + 12'(i));
    check("R3 pointer after five stores", wptr, 5);
    cyc(0, 1, 0, 12'h777);
    check("R4 no store when masked", mem_we, 0);
    check("R4 pointer advances when masked", wptr, 6);
    cyc(0, 1, 0, 12'h777);
    check("R4 pointer advances again", wptr, 7);
    cyc(0, 1, 1, 12'h207);
    check("R4 store resumes at addr 7", mem_addr, 7);
    cyc(0, 0, 0, 0);
    check("R4 ram[5] kept", ram[5], 12'h105);
    check("R4 ram[6] kept", ram[6], 12'h106);
    check("R3 ram[4] new", ram[4], 12'h204);
    check("R3 ram[7] new", ram[7], 12'h207);
    check("R4 ram[8] old", ram[8], 12'h108);
  endtask

  task automatic t_guard;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(1, 1, 1, 12'h300);
    check("R7 first strobe accepted", wptr, 0);
    check("R7 no error yet", rst_err, 0);
    cyc(1, 1, 1, 12'h301);
    check("R7 early strobe ignored, pointer advanced", wptr, 1);
    check("R7 early strobe acts as store", mem_we, 1);
    check("R7 error flag set", rst_err, 1);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check("R7 flag sticky", rst_err, 1);
    cyc(1, 1, 1, 12'h302);
    check("R7 strobe after two low cycles accepted", wptr, 0);
    check("R7 flag still set", rst_err, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_state();
    t_first_fill();
    t_hold();
    t_masked_overwrite();
    t_guard();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule